// File: doc/BRIEF.md
# Hardware Thread Select Controller

This block decides, every clock cycle, which of several hardware thread contexts may issue into a shared pipeline. Each context holds its own program counter and register state outside this block. A thread is therefore chosen by identifier only, and a switch costs no save or restore. The controller looks at one stall flag per thread, a long-latency stall flag for the thread that is currently selected, and a policy select. It returns a registered thread identifier, an issue-valid qualifier and a one-cycle switch pulse.

Two policies can be chosen at run time. The interleaved policy moves to a different ready thread after every cycle, in round-robin order, and passes over any thread whose stall flag is high. The switch-on-long-stall policy stays with the current thread through short stalls, withholding issue while it waits. It moves on only when the current thread reports a long-latency stall, such as an outer cache miss. All decisions are made from inputs sampled at a rising edge and appear on the outputs right after that edge.

Top module: `thread_select_ctrl`

## Requirements
- R1: While `rst` is high at a rising edge, the outputs after that edge are `sel_tid` = 0, `issue_valid` = 0 and `switch_pulse` = 0, and the round-robin position restarts from thread 0.
- R2: With `coarse_mode` = 0, the next `sel_tid` is the first thread i with `thread_stall[i]` = 0 found by scanning from the thread after the current `sel_tid`, wrapping past N-1 to 0, with the current thread checked last. `issue_valid` is 1 in that case.
- R3: With `coarse_mode` = 0 and two or more threads not stalled, `sel_tid` differs from its previous value on every cycle.
- R4: With `coarse_mode` = 0 and every `thread_stall` bit high, `issue_valid` goes to 0 and `sel_tid` holds. The next scan starts from the held thread.
- R5: With `coarse_mode` = 1 and `long_stall` = 0, `sel_tid` does not change while the block is not waiting. `issue_valid` equals the inverse of that thread's `thread_stall` bit, so a short stall only withholds issue.
- R6: With `coarse_mode` = 1 and `long_stall` = 1, the next `sel_tid` is the first thread with `thread_stall` = 0 after the current one in round-robin order, and the current thread is never chosen.
- R7: When a long stall finds no other ready thread, `issue_valid` goes to 0 and `sel_tid` holds while the block waits. On each later cycle it scans from the thread after the current one. The current thread becomes eligible again only once `long_stall` is 0 and its own stall bit is 0.
- R8: `switch_pulse` is 1 for exactly the cycles in which `sel_tid` differs from its value in the cycle before.
- R9: `coarse_mode` is sampled every edge, so a policy change applies to the very next decision. `long_stall` has no effect while `coarse_mode` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| coarse_mode | input | 1 | 0 selects per-cycle interleaving, 1 selects switch-on-long-stall |
| thread_stall | input | NUM_THREADS | Bit i high means thread i cannot issue now |
| long_stall | input | 1 | The selected thread has hit a long-latency stall |
| sel_tid | output | TID_W | Thread chosen to issue this cycle |
| issue_valid | output | 1 | The chosen thread may issue this cycle |
| switch_pulse | output | 1 | High for one cycle when `sel_tid` changes |

## Verification
The bench makes the interleaved scan wrap past the top thread while the thread right after the last issued one is stalled. A picker that restarted from thread 0, or that forgot to wrap, would land on the wrong identifier there. It also leaves only the previously issued thread ready, so the scan must return to that same thread with no switch pulse, and it stalls every thread to confirm that issue drops while the identifier holds. In the long-stall policy it checks that short stalls never move the selection and that a long stall never re-selects the stalled thread. It also drives a wait with no ready thread and ends it two ways: first by the stalled thread recovering, then by another thread becoming ready. A design that dropped the waiting state would resume a thread that is still long-stalled.

// File: rtl/tsel_pkg.sv
package tsel_pkg;
  typedef enum logic {
    POL_INTERLEAVE = 1'b0,
    POL_ON_LONG    = 1'b1
  } sel_policy_e;
endpackage

// File: rtl/tsel_elig_mask.sv
// Builds the set of threads that may be chosen by the next scan.
module tsel_elig_mask #(
  parameter int NUM_THREADS = 4,
  localparam int TID_W = $clog2(NUM_THREADS)
) (
  input  logic [NUM_THREADS-1:0] stall,
  input  logic                   block_cur,
  input  logic [TID_W-1:0]       cur,
  output logic [NUM_THREADS-1:0] elig
);
  for (genvar g = 0; g < NUM_THREADS; g++) begin : g_bit
    assign elig[g] = !stall[g] && !(block_cur && (cur == TID_W'(g)));
  end
endmodule

// File: rtl/tsel_rr_pick.sv
// First set bit of mask, scanning upward from base and wrapping.
module tsel_rr_pick #(
  parameter int NUM_THREADS = 4,
  localparam int TID_W = $clog2(NUM_THREADS)
) (
  input  logic [NUM_THREADS-1:0] mask,
  input  logic [TID_W-1:0]       base,
  output logic                   found,
  output logic [TID_W-1:0]       idx
);
  always_comb begin
    int unsigned pos;
    found = 1'b0;
    idx   = '0;
    pos   = 0;
    for (int k = 0; k < NUM_THREADS; k++) begin
      pos = (int'(base) + k) % NUM_THREADS;
      if (!found && mask[pos]) begin
        found = 1'b1;
        idx   = TID_W'(pos);
      end
    end
  end
endmodule

// File: rtl/thread_select_ctrl.sv
module thread_select_ctrl
  import tsel_pkg::*;
#(
  parameter int NUM_THREADS = 4,
  localparam int TID_W = $clog2(NUM_THREADS)
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   coarse_mode,
  input  logic [NUM_THREADS-1:0] thread_stall,
  input  logic                   long_stall,
  output logic [TID_W-1:0]       sel_tid,
  output logic                   issue_valid,
  output logic                   switch_pulse
);
  sel_policy_e pol;
  logic        waiting_q, waiting_d;
  logic [TID_W-1:0]       scan_base;
  logic [NUM_THREADS-1:0] elig;
  logic                   pick_found;
  logic [TID_W-1:0]       pick_idx;
  logic [TID_W-1:0]       tid_d;
  logic                   valid_d, sw_d;
  logic                   need_scan;

  assign pol = sel_policy_e'(coarse_mode);
  assign scan_base = (sel_tid == TID_W'(NUM_THREADS - 1)) ? '0 : sel_tid + 1'b1;

  tsel_elig_mask #(.NUM_THREADS(NUM_THREADS)) u_mask (
    .stall     (thread_stall),
    .block_cur (pol == POL_ON_LONG && long_stall),
    .cur       (sel_tid),
    .elig      (elig)
  );

  tsel_rr_pick #(.NUM_THREADS(NUM_THREADS)) u_pick (
    .mask  (elig),
    .base  (scan_base),
    .found (pick_found),
    .idx   (pick_idx)
  );

  assign need_scan = (pol == POL_INTERLEAVE) || long_stall || waiting_q;

  always_comb begin
    tid_d     = sel_tid;
    valid_d   = 1'b0;
    waiting_d = 1'b0;
    if (need_scan) begin
      if (pick_found) begin
        tid_d   = pick_idx;
        valid_d = 1'b1;
      end else begin
        waiting_d = (pol == POL_ON_LONG);
      end
    end else begin
      valid_d = !thread_stall[sel_tid];
    end
    sw_d = (tid_d != sel_tid);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sel_tid      <= '0;
      issue_valid  <= 1'b0;
      switch_pulse <= 1'b0;
      waiting_q    <= 1'b0;
    end else begin
      sel_tid      <= tid_d;
      issue_valid  <= valid_d;
      switch_pulse <= sw_d;
      waiting_q    <= waiting_d;
    end
  end

  // R3: with two or more ready threads the interleaved policy always moves
  a_r3_moves_each_cycle: assert property (@(posedge clk) disable iff (rst)
    (!coarse_mode && $countones(~thread_stall) >= 2) |=> (sel_tid != $past(sel_tid)));

  // R2: an issuing thread was not stalled when it was chosen
  a_r2_issue_not_stalled: assert property (@(posedge clk) disable iff (rst)
    (!coarse_mode) |=> (!issue_valid || !(|($past(thread_stall) & (NUM_THREADS'(1) << sel_tid)))));

  // R4: all threads stalled gives no issue and a held selection
  a_r4_all_stalled_hold: assert property (@(posedge clk) disable iff (rst)
    (!coarse_mode && (&thread_stall)) |=> (!issue_valid && $stable(sel_tid)));

  // R5: no long stall while issuing keeps the same thread
  a_r5_keep_thread: assert property (@(posedge clk) disable iff (rst)
    (coarse_mode && !long_stall && issue_valid) |=> $stable(sel_tid));

  // R6: a long stall never re-selects the stalled thread with issue
  a_r6_leave_stalled: assert property (@(posedge clk) disable iff (rst)
    (coarse_mode && long_stall) |=> (!issue_valid || (sel_tid != $past(sel_tid))));

  // R8: the switch pulse marks exactly the cycles where the selection moved
  a_r8_switch_marks_change: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (switch_pulse == (sel_tid != $past(sel_tid))));
endmodule

// File: tb/thread_select_ctrl_bench.sv
`timescale 1ns/1ps
module thread_select_ctrl_bench;
  localparam int N = 4;
  localparam int NV = 21;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic coarse_mode = 1'b0;
  logic [N-1:0] thread_stall = '0;
  logic long_stall = 1'b0;
  logic [1:0] sel_tid;
  logic issue_valid, switch_pulse;

  int n_chk = 0;
  int n_bad = 0;
  int cyc = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  thread_select_ctrl #(.NUM_THREADS(N)) u_thread_select_ctrl (
    .clk (clk), .rst (rst), .coarse_mode (coarse_mode),
    .thread_stall (thread_stall), .long_stall (long_stall),
    .sel_tid (sel_tid), .issue_valid (issue_valid), .switch_pulse (switch_pulse)
  );

  // {req[3:0], coarse, long, stall[3:0] (bit i = thread i), tid[1:0], valid, switch}
  localparam logic [13:0] VEC [0:NV-1] = '{
    14'b0010_0_0_0000_01_1_1, // R2 from reset, thread 1
    14'b0011_0_0_0000_10_1_1, // R3 moves on
    14'b0010_0_0_1000_00_1_1, // R2 skip 3, wrap to 0
    14'b0010_0_0_0110_11_1_1, // R2 skip 1 and 2
    14'b0100_0_0_1111_11_0_0, // R4 all stalled
    14'b0100_0_0_1111_11_0_0, // R4 still held
    14'b0010_0_0_0111_11_1_0, // R2 only same thread ready
    14'b0011_0_0_0000_00_1_1, // R3
    14'b0101_1_0_0000_00_1_0, // R5 stays
    14'b0101_1_0_0001_00_0_0, // R5 short stall waits
    14'b0101_1_0_0000_00_1_0, // R5 resumes
    14'b0110_1_1_0010_10_1_1, // R6 skip stalled 1, go to 2
    14'b0101_1_0_0000_10_1_0, // R5 stays on 2
    14'b0111_1_1_1011_10_0_0, // R7 nothing ready, wait
    14'b0111_1_0_1011_10_1_0, // R7 current recovers
    14'b0111_1_1_1111_10_0_0, // R7 wait again
    14'b0111_1_0_1110_00_1_1, // R7 other thread ready first
    14'b1000_1_0_0000_00_1_0, // R8 no change, no pulse
    14'b1001_0_0_0000_01_1_1, // R9 switch to interleave
    14'b1001_1_1_0000_10_1_1, // R9 back to long-stall policy
    14'b1001_0_1_0000_11_1_1  // R9 long_stall ignored when interleaving
  };

  task automatic check(input int req, input string what, input int got, input int exp);
    n_chk++;
    if (got != exp) begin
      n_bad++;
      $display("FAIL R%0d %s: got %0d expected %0d", req, what, got, exp);
    end
  endtask

  task automatic check_out(input int req, input int et, input int ev, input int es);
    check(req, "sel_tid", int'(sel_tid), et);
    check(req, "issue_valid", int'(issue_valid), ev);
    check(req, "switch_pulse", int'(switch_pulse), es);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 5000 && !done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: got %0d cycles expected under 5000", cyc);
      finish_run();
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    check_out(1, 0, 0, 0); // R1 reset state
    @(negedge clk);
    rst = 1'b0;
    for (int i = 0; i < NV; i++) begin
      coarse_mode  = VEC[i][9];
      long_stall   = VEC[i][8];
      thread_stall = VEC[i][7:4];
      @(posedge clk);
      #1;
      check_out(int'(VEC[i][13:10]), int'(VEC[i][3:2]), int'(VEC[i][1]), int'(VEC[i][0]));
      @(negedge clk);
    end
    // R1 mid-run reset clears the selection and rotation
    rst = 1'b1;
    coarse_mode = 1'b0;
    long_stall = 1'b0;
    thread_stall = '0;
    @(posedge clk);
    #1;
    check_out(1, 0, 0, 0);
    @(negedge clk);
    rst = 1'b0;
    @(posedge clk);
    #1;
    check_out(1, 1, 1, 1); // R1 rotation restarts after thread 0
    @(negedge clk);
    // R8 pulse lasts one cycle: hold by stalling everything
    thread_stall = '1;
    @(posedge clk);
    #1;
    check_out(8, 1, 0, 0);
    @(negedge clk);
    finish_run();
  end
endmodule